// File: doc/BRIEF.md
# Grouped External Interrupt Router

The block maps pad inputs from several ports onto sixteen external interrupt lines. Each line holds its own routing choice: a source port, and a pin taken from the line's aligned group of four pins. Lines 0-3 reach pins 0-3, lines 4-7 reach pins 4-7, and so on. Each line also holds a rising-edge enable and a falling-edge enable. The pads pass through a two-flop synchroniser. A qualifying transition on the routed pin makes that line pending.

Pending flags and enable bits are changed only through separate set and clear write vectors. Both register values are visible on output ports. Interrupt requests leave the block on two wires: one carries the enabled pending lines with even numbers, the other those with odd numbers. Writing a line's routing clears that line's pending flag and leaves its enable bit as it was. A parameter mask states which pins exist on each port. A line routed to a pin that does not exist never becomes pending from hardware.

Top module: `extint_router`

## Requirements
- R1: After reset the pending vector `if_o`, the enable vector `ien_o` and both request outputs are zero, and no line has an edge enabled.
- R2: Line n routed with port code p and offset k watches pad bit `pads_i[p*16 + 4*(n/4) + k]`. Transitions on any other pad bit leave line n's flag unchanged.
- R3: A one in `if_set_i` bit n makes line n pending on the next clock edge. A one in `if_clr_i` bit n clears it. When both are one for the same bit, the line becomes pending.
- R4: A one in `ien_set_i` bit n sets enable bit n and a one in `ien_clr_i` clears it, with set winning over clear. Bits that neither vector names keep their value, and `ien_o` shows the current enables.
- R5: With its rising enable set, a line becomes pending on the third rising clock edge after a low-to-high change on its pad, counting the first edge that samples the pad. It is not yet pending after the second edge.
- R6: The falling enable works independently of the rising enable. It makes the line pending after a high-to-low change with the same latency. With both enables set, a line reacts to either direction.
- R7: A line with neither edge enabled never becomes pending from a pad change, and a line with only one direction enabled ignores the other direction.
- R8: A routing write to line n clears line n's pending flag on the next clock edge. It leaves `ien_o` and every other line's flag unchanged.
- R9: A detected edge on line n in the same cycle as a one in `if_clr_i` bit n leaves the line pending.
- R10: A line routed to a pin whose bit in `VALID_MASK` is zero never becomes pending from a pad change. With the default mask, port 2 has only pins 0-7 and port 3 has no pins.
- R11: `irq_even_o` is high exactly when some even-numbered line is both pending and enabled, and `irq_odd_o` is high exactly when some odd-numbered line is both.
- R12: A pending flag stays set until it is cleared by `if_clr_i` or a routing write. Returning the pad to its earlier level does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pads_i | input | NUM_PORTS*PINS_PER_PORT | Pad levels, bit p*PINS_PER_PORT+i is pin i of port p |
| cfg_we_i | input | 1 | Routing write strobe |
| cfg_line_i | input | LINE_W | Line written by the routing write |
| cfg_port_i | input | PORT_W | Source port for the line |
| cfg_off_i | input | OFF_W | Pin offset inside the line's group |
| cfg_rise_i | input | 1 | Rising-edge enable for the line |
| cfg_fall_i | input | 1 | Falling-edge enable for the line |
| if_set_i | input | NUM_LINES | Pending set vector |
| if_clr_i | input | NUM_LINES | Pending clear vector |
| ien_set_i | input | NUM_LINES | Enable set vector |
| ien_clr_i | input | NUM_LINES | Enable clear vector |
| if_o | output | NUM_LINES | Pending flags |
| ien_o | output | NUM_LINES | Enable bits |
| irq_even_o | output | 1 | Request from even-numbered lines |
| irq_odd_o | output | 1 | Request from odd-numbered lines |

## Verification
Rising steps, falling steps and full pulses are driven on routed pins with each combination of the edge enables, which shows that the two directions are independent and that the latency is exact. The bench also toggles pads next to the routed one and toggles the same pin number on a different port, so a routing error that picks the wrong bit cannot go unnoticed. Pins that exist and pins that do not exist on a partly populated port tell the valid mask apart from the port decode. Lines are made pending one at a time, each with its enable on and off, which exercises the even/odd split of the requests. Same-cycle set against clear, and an edge arriving during a clear, fix the priority rules.

// File: rtl/exti_pkg.sv
package exti_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
   } exti_edge_sel_t;

   function automatic bit is_pow2(int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
   parameter int WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] now_o,
   output logic [WIDTH-1:0] prev_o
);
   logic [WIDTH-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         now_o  <= '0;
         prev_o <= '0;
      end else begin
         meta_q <= async_i;
         now_o  <= meta_q;
         prev_o <= now_o;
      end
   end
endmodule

// File: rtl/exti_line.sv
module exti_line
   import exti_pkg::*;
#(
   parameter int LINE_IDX      = 0,
   parameter int NUM_PORTS     = 4,
   parameter int PINS_PER_PORT = 16,
   parameter int GROUP_SIZE    = 4,
   parameter int PORT_W        = 2,
   parameter int OFF_W         = 2,
   parameter logic [NUM_PORTS*PINS_PER_PORT-1:0] VALID_MASK = '1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_i,
   input  logic [PORT_W-1:0]                  port_i,
   input  logic [OFF_W-1:0]                   off_i,
   input  exti_edge_sel_t                     sel_i,
   input  logic [NUM_PORTS*PINS_PER_PORT-1:0] now_i,
   input  logic [NUM_PORTS*PINS_PER_PORT-1:0] prev_i,
   output logic                               edge_o
);
   localparam int PIN_W = $clog2(PINS_PER_PORT);
   localparam int BASE  = (LINE_IDX / GROUP_SIZE) * GROUP_SIZE;

   logic [PORT_W-1:0]       port_q;
   logic [OFF_W-1:0]        off_q;
   exti_edge_sel_t          sel_q;
   logic [PIN_W-1:0]        pin_idx;
   logic [PORT_W+PIN_W-1:0] flat_idx;
   logic                    in_range, usable, cur, old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q <= '0;
         off_q  <= '0;
         sel_q  <= '0;
      end else if (wr_i) begin
         port_q <= port_i;
         off_q  <= off_i;
         sel_q  <= sel_i;
      end
   end

   always_comb begin
      pin_idx  = PIN_W'(BASE) + PIN_W'(off_q);
      flat_idx = {port_q, pin_idx};
      in_range = (int'(port_q) < NUM_PORTS);
      usable   = in_range && VALID_MASK[flat_idx];
      cur      = usable && now_i[flat_idx];
      old      = usable && prev_i[flat_idx];
      edge_o   = (sel_q.rise && cur && !old) || (sel_q.fall && !cur && old);
   end
endmodule

// File: rtl/exti_flags.sv
module exti_flags #(
   parameter int NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] sw_set_i,
   input  logic [NUM_LINES-1:0] sw_clr_i,
   input  logic [NUM_LINES-1:0] cfg_clr_i,
   input  logic [NUM_LINES-1:0] hw_set_i,
   input  logic [NUM_LINES-1:0] en_set_i,
   input  logic [NUM_LINES-1:0] en_clr_i,
   output logic [NUM_LINES-1:0] pend_o,
   output logic [NUM_LINES-1:0] en_o,
   output logic                 req_even_o,
   output logic                 req_odd_o
);
   logic [NUM_LINES-1:0] even_m;
   logic [NUM_LINES-1:0] live;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_par
      assign even_m[g] = ((g % 2) == 0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= '0;
         en_o   <= '0;
      end else begin
         pend_o <= (pend_o & ~(sw_clr_i | cfg_clr_i)) | sw_set_i | hw_set_i;
         en_o   <= (en_o & ~en_clr_i) | en_set_i;
      end
   end

   assign live       = pend_o & en_o;
   assign req_even_o = |(live & even_m);
   assign req_odd_o  = |(live & ~even_m);
endmodule

// File: rtl/extint_router.sv
module extint_router
   import exti_pkg::*;
#(
   parameter int NUM_PORTS     = 4,
   parameter int PINS_PER_PORT = 16,
   parameter int NUM_LINES     = 16,
   parameter int GROUP_SIZE    = 4,
   parameter logic [NUM_PORTS*PINS_PER_PORT-1:0] VALID_MASK = 64'h0000_00FF_FFFF_FFFF,
   localparam int LINE_W = $clog2(NUM_LINES),
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int OFF_W  = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pads_i,
   input  logic                               cfg_we_i,
   input  logic [LINE_W-1:0]                  cfg_line_i,
   input  logic [PORT_W-1:0]                  cfg_port_i,
   input  logic [OFF_W-1:0]                   cfg_off_i,
   input  logic                               cfg_rise_i,
   input  logic                               cfg_fall_i,
   input  logic [NUM_LINES-1:0]               if_set_i,
   input  logic [NUM_LINES-1:0]               if_clr_i,
   input  logic [NUM_LINES-1:0]               ien_set_i,
   input  logic [NUM_LINES-1:0]               ien_clr_i,
   output logic [NUM_LINES-1:0]               if_o,
   output logic [NUM_LINES-1:0]               ien_o,
   output logic                               irq_even_o,
   output logic                               irq_odd_o
);
   localparam int TOTAL = NUM_PORTS * PINS_PER_PORT;

   if (!is_pow2(GROUP_SIZE)) begin : g_bad_group
      $error("GROUP_SIZE must be a power of two");
   end
   if (!is_pow2(PINS_PER_PORT)) begin : g_bad_pins
      $error("PINS_PER_PORT must be a power of two");
   end
   if ((NUM_LINES % GROUP_SIZE) != 0 || NUM_LINES > PINS_PER_PORT) begin : g_bad_lines
      $error("NUM_LINES must be a multiple of GROUP_SIZE and fit in a port");
   end

   logic [TOTAL-1:0]     pad_now, pad_prev;
   logic [NUM_LINES-1:0] cfg_hit;
   logic [NUM_LINES-1:0] line_edge;
   exti_edge_sel_t       wr_sel;

   assign wr_sel = '{rise: cfg_rise_i, fall: cfg_fall_i};

   exti_sync #(.WIDTH(TOTAL)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(pads_i),
      .now_o  (pad_now),
      .prev_o (pad_prev)
   );

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      assign cfg_hit[g] = cfg_we_i && (cfg_line_i == LINE_W'(g));

      exti_line #(
         .LINE_IDX     (g),
         .NUM_PORTS    (NUM_PORTS),
         .PINS_PER_PORT(PINS_PER_PORT),
         .GROUP_SIZE   (GROUP_SIZE),
         .PORT_W       (PORT_W),
         .OFF_W        (OFF_W),
         .VALID_MASK   (VALID_MASK)
      ) u_line (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_i  (cfg_hit[g]),
         .port_i(cfg_port_i),
         .off_i (cfg_off_i),
         .sel_i (wr_sel),
         .now_i (pad_now),
         .prev_i(pad_prev),
         .edge_o(line_edge[g])
      );
   end

   exti_flags #(.NUM_LINES(NUM_LINES)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_set_i  (if_set_i),
      .sw_clr_i  (if_clr_i),
      .cfg_clr_i (cfg_hit),
      .hw_set_i  (line_edge),
      .en_set_i  (ien_set_i),
      .en_clr_i  (ien_clr_i),
      .pend_o    (if_o),
      .en_o      (ien_o),
      .req_even_o(irq_even_o),
      .req_odd_o (irq_odd_o)
   );
endmodule

// File: rtl/extint_router_chk.sv
module extint_router_chk #(
   parameter int NUM_LINES = 16,
   parameter int LINE_W    = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we_i,
   input logic [LINE_W-1:0]    cfg_line_i,
   input logic [NUM_LINES-1:0] if_set_i,
   input logic [NUM_LINES-1:0] if_clr_i,
   input logic [NUM_LINES-1:0] ien_set_i,
   input logic [NUM_LINES-1:0] ien_clr_i,
   input logic [NUM_LINES-1:0] if_o,
   input logic [NUM_LINES-1:0] ien_o,
   input logic                 irq_even_o,
   input logic                 irq_odd_o,
   input logic [NUM_LINES-1:0] edge_i
);
   logic [NUM_LINES-1:0] even_m;
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_par
      assign even_m[g] = ((g % 2) == 0);
   end

   p_set_pends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|if_set_i) |=> ((if_o & $past(if_set_i)) == $past(if_set_i)));

   p_ien_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|ien_set_i) |=> ((ien_o & $past(ien_set_i)) == $past(ien_set_i)));

   p_ien_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ien_clr_i & ~ien_set_i)) |=> ((ien_o & $past(ien_clr_i & ~ien_set_i)) == '0));

   p_ien_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_set_i == '0 && ien_clr_i == '0) |=> $stable(ien_o));

   p_cfg_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && !if_set_i[cfg_line_i] && !edge_i[cfg_line_i])
      |=> (if_o[$past(cfg_line_i)] == 1'b0));

   p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_i) |=> ((if_o & $past(edge_i)) == $past(edge_i)));

   p_flag_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((if_o & ~$past(if_o) & ~$past(if_set_i | edge_i)) == '0));

   p_even_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_even_o |-> ((if_o & ien_o & even_m) != '0));

   p_odd_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_odd_o |-> ((if_o & ien_o & ~even_m) != '0));
endmodule

bind extint_router extint_router_chk #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we_i  (cfg_we_i),
   .cfg_line_i(cfg_line_i),
   .if_set_i  (if_set_i),
   .if_clr_i  (if_clr_i),
   .ien_set_i (ien_set_i),
   .ien_clr_i (ien_clr_i),
   .if_o      (if_o),
   .ien_o     (ien_o),
   .irq_even_o(irq_even_o),
   .irq_odd_o (irq_odd_o),
   .edge_i    (line_edge)
);

// File: tb/tb_extint_router.sv
module tb_extint_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] pads = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_line = '0;
   logic [1:0]  cfg_port = '0;
   logic [1:0]  cfg_off = '0;
   logic        cfg_rise = 1'b0;
   logic        cfg_fall = 1'b0;
   logic [15:0] if_set = '0, if_clr = '0, ien_set = '0, ien_clr = '0;
   logic [15:0] if_o, ien_o;
   logic        irq_even, irq_odd;
   int          checks = 0;
   int          failures = 0;

   always #10 clk = ~clk;

   extint_router dut (
      .clk(clk), .rst_n(rst_n), .pads_i(pads),
      .cfg_we_i(cfg_we), .cfg_line_i(cfg_line), .cfg_port_i(cfg_port),
      .cfg_off_i(cfg_off), .cfg_rise_i(cfg_rise), .cfg_fall_i(cfg_fall),
      .if_set_i(if_set), .if_clr_i(if_clr), .ien_set_i(ien_set), .ien_clr_i(ien_clr),
      .if_o(if_o), .ien_o(ien_o), .irq_even_o(irq_even), .irq_odd_o(irq_odd)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_flags(logic [15:0] s, logic [15:0] c, logic [15:0] es, logic [15:0] ec);
      if_set = s; if_clr = c; ien_set = es; ien_clr = ec;
      step(1);
      if_set = '0; if_clr = '0; ien_set = '0; ien_clr = '0;
   endtask

   task automatic route(int line, int port, int off, bit rise, bit fall);
      cfg_we = 1'b1; cfg_line = 4'(line); cfg_port = 2'(port); cfg_off = 2'(off);
      cfg_rise = rise; cfg_fall = fall;
      step(1);
      cfg_we = 1'b0;
   endtask

   // Drive one pad and check the line's flag after the edge latency.
   task automatic pad_edge(string req, int line, int idx, bit val, bit expect_flag);
      wr_flags('0, 16'hFFFF, '0, '0);
      pads[idx] = val;
      step(2);
      if (expect_flag) chk({req, " not yet pending"}, 32'(if_o[line]), 32'd0);
      step(1);
      chk({req, " pending after edge"}, 32'(if_o[line]), 32'(expect_flag));
      step(2);
   endtask

   task automatic t_reset;
      chk("R1 if_o", 32'(if_o), 32'h0);
      chk("R1 ien_o", 32'(ien_o), 32'h0);
      chk("R1 irqs", {30'd0, irq_even, irq_odd}, 32'd0);
      pads[0] = 1'b1; step(4);
      chk("R1 no edge enabled at reset", 32'(if_o), 32'h0);
      pads[0] = 1'b0; step(4);
   endtask

   task automatic t_sw_flags;
      wr_flags(16'h00F0, '0, '0, '0);
      chk("R3 set", 32'(if_o), 32'h00F0);
      wr_flags('0, 16'h0030, '0, '0);
      chk("R3 clear", 32'(if_o), 32'h00C0);
      wr_flags(16'h0100, 16'h0140, '0, '0);
      chk("R3 set beats clear", 32'(if_o), 32'h0180);
      wr_flags('0, 16'hFFFF, '0, '0);
      chk("R3 clear all", 32'(if_o), 32'h0);
   endtask

   task automatic t_ien;
      wr_flags('0, '0, 16'hA5A5, '0);
      chk("R4 set", 32'(ien_o), 32'hA5A5);
      wr_flags('0, '0, '0, 16'h0005);
      chk("R4 clear", 32'(ien_o), 32'hA5A0);
      wr_flags('0, '0, 16'h0002, 16'h0022);
      chk("R4 set beats clear", 32'(ien_o), 32'hA582);
      wr_flags('0, '0, '0, 16'hFFFF);
      chk("R4 clear all", 32'(ien_o), 32'h0);
   endtask

   task automatic t_irq;
      wr_flags('0, '0, 16'h0003, '0);
      wr_flags(16'h0004, '0, '0, '0);
      chk("R11 pending but disabled", {30'd0, irq_even, irq_odd}, 32'd0);
      wr_flags(16'h0001, 16'h0004, '0, '0);
      chk("R11 even line", {30'd0, irq_even, irq_odd}, 32'd2);
      wr_flags(16'h0002, 16'h0001, '0, '0);
      chk("R11 odd line", {30'd0, irq_even, irq_odd}, 32'd1);
      wr_flags(16'h0001, '0, '0, '0);
      chk("R11 both", {30'd0, irq_even, irq_odd}, 32'd3);
      wr_flags('0, 16'hFFFF, '0, 16'hFFFF);
   endtask

   task automatic t_rise;
      route(5, 1, 2, 1'b1, 1'b0);            // pin 6 of port 1 -> pad 22
      pad_edge("R5 rise", 5, 22, 1'b1, 1'b1);
      pad_edge("R7 fall ignored when rise only", 5, 22, 1'b0, 1'b0);
      pad_edge("R2 same pin other port", 5, 6, 1'b1, 1'b0);
      pad_edge("R2 neighbour pin", 5, 21, 1'b1, 1'b0);
      pads[6] = 1'b0; pads[21] = 1'b0; step(4);
   endtask

   task automatic t_fall;
      pads[9] = 1'b1; step(4);
      route(9, 0, 1, 1'b0, 1'b1);            // pin 9 of port 0
      pad_edge("R6 fall", 9, 9, 1'b0, 1'b1);
      pad_edge("R6 rise ignored when fall only", 9, 9, 1'b1, 1'b0);
      route(9, 0, 1, 1'b1, 1'b1);
      pad_edge("R6 both: fall", 9, 9, 1'b0, 1'b1);
      pad_edge("R6 both: rise", 9, 9, 1'b1, 1'b1);
      pads[9] = 1'b0; step(4);
   endtask

   task automatic t_none;
      route(0, 0, 3, 1'b0, 1'b0);
      pad_edge("R7 no enables rise", 0, 3, 1'b1, 1'b0);
      pad_edge("R7 no enables fall", 0, 3, 1'b0, 1'b0);
   endtask

   task automatic t_cfg_clear;
      wr_flags(16'h0018, '0, 16'h0008, '0);
      route(3, 1, 0, 1'b1, 1'b0);
      chk("R8 line flag cleared, others kept", 32'(if_o), 32'h0010);
      chk("R8 enable untouched", 32'(ien_o), 32'h0008);
      wr_flags('0, 16'hFFFF, '0, 16'hFFFF);
   endtask

   task automatic t_race;
      route(14, 0, 2, 1'b1, 1'b0);           // pin 14 of port 0
      wr_flags('0, 16'hFFFF, '0, '0);
      pads[14] = 1'b1;
      step(2);
      if_clr = 16'h4000;                     // clear in the edge cycle
      step(1);
      if_clr = '0;
      chk("R9 edge beats clear", 32'(if_o[14]), 32'd1);
      step(5);
      chk("R12 flag held", 32'(if_o[14]), 32'd1);
      pads[14] = 1'b0; step(4);
      chk("R12 pad return keeps flag", 32'(if_o[14]), 32'd1);
      wr_flags('0, 16'hFFFF, '0, '0);
      chk("R12 cleared by clear port", 32'(if_o[14]), 32'd0);
   endtask

   task automatic t_invalid;
      route(12, 2, 0, 1'b1, 1'b1);           // port 2 pin 12 missing
      pad_edge("R10 missing pin rise", 12, 44, 1'b1, 1'b0);
      pad_edge("R10 missing pin fall", 12, 44, 1'b0, 1'b0);
      route(1, 3, 1, 1'b1, 1'b1);            // port 3 has no pins
      pad_edge("R10 empty port", 1, 49, 1'b1, 1'b0);
      route(2, 2, 2, 1'b1, 1'b0);            // port 2 pin 2 exists
      pad_edge("R10 present pin on partial port", 2, 34, 1'b1, 1'b1);
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_sw_flags();
      t_ien();
      t_irq();
      t_rise();
      t_fall();
      t_none();
      t_cfg_clear();
      t_race();
      t_invalid();
      finish_run();
   end
endmodule